// File: doc/BRIEF.md
# Fetch-Stage Branch Target Cache

This block sits beside the instruction fetch address generator and predicts taken branches before they reach execution. Each cycle the current fetch address is looked up in a small direct-mapped table. When a valid entry with a matching tag is found, the block raises a flush strobe for the sequentially fetched stream and loads the stored target as the next fetch address. When there is no match, fetch moves on by one 4-byte word.

Resolved branches from the execute stage train the table through an update port. A branch that resolves taken writes or overwrites its entry. A branch that resolves not taken removes its entry, but only if that entry belongs to the same branch. Targets with an odd byte address are refused. Software controls an enable bit that turns off all predictions. A global invalidate input empties the table in one cycle.

Top module: `btb_fetch_top`

## Requirements
- R1: During reset and in the first cycle after reset is released, `fetch_addr` equals the `RESET_PC` parameter (default 0x0000_1000), `fetch_flush` is 0, and every table entry is empty.
- R2: In a cycle with no hit, `fetch_flush` is 0 and on the next cycle `fetch_addr` is the current address plus 4.
- R3: A hit is a valid entry at index `fetch_addr[7:2]` whose stored tag equals `fetch_addr[31:8]`. A hit raises `fetch_flush` in the same cycle, and on the next cycle `fetch_addr` equals the entry's stored target.
- R4: While `bp_enable` is 0, `fetch_flush` stays 0 and fetch is sequential. Entries are kept, and they predict again once `bp_enable` returns to 1.
- R5: An update with `upd_valid`=1, `upd_taken`=1 and an even `upd_target` writes entry `upd_pc[7:2]` as valid, with tag `upd_pc[31:8]` and target `upd_target`. The new entry is visible to lookups from the next cycle on.
- R6: An update with `upd_valid`=1 and `upd_taken`=0 clears the entry at `upd_pc[7:2]` only when that entry is valid and its tag equals `upd_pc[31:8]`. Otherwise the entry is left as it was.
- R7: A taken update whose `upd_target[0]` is 1 changes nothing. An existing entry at that index keeps its old target.
- R8: A lookup in the same cycle as an update to the same index uses the table contents from before the update.
- R9: `flush_all`=1 empties every entry at the next clock edge. It takes priority over an update in the same cycle. A lookup in that same cycle still uses the old contents.
- R10: An address that maps to a valid entry but has a different tag is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_enable | input | 1 | Software enable for predictions |
| flush_all | input | 1 | Empties all entries |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved branch target |
| upd_taken | input | 1 | Branch resolved taken |
| fetch_addr | output | 32 | Current fetch address |
| fetch_flush | output | 1 | Hit: discard the sequential stream and redirect |

## Verification
The hardest cases to reach are a fetch that revisits an entry after that entry has been modified, because the only way to steer the fetch address is through predictions the bench has installed itself. The stimulus therefore plants chains of taken branches that loop fetch back through earlier addresses. This lets each revisit show a refused odd target, a tag-guarded clear, an alias miss, or the result of an invalidate. The same-cycle collision cases, an update or an invalidate arriving on the very cycle that the index is looked up, are timed by issuing the update while the fetch address sits on that index.

// File: rtl/btb_pkg.sv
// Package: shared sizing for the fetch-stage branch target cache.
// Assumes word-based fetch with 2-byte minimum instruction alignment.
package btb_pkg;
    parameter int BTB_ADDR_W  = 32;
    parameter int BTB_IDX_W   = 6;
    parameter int BTB_IDX_LSB = 2;
    parameter int BTB_TAG_W   = BTB_ADDR_W - BTB_IDX_W - BTB_IDX_LSB;
endpackage

// File: rtl/btb_store.sv
// Module: btb_store
// Holds the direct-mapped entries (valid, tag, target) and applies
// execution-side training and global invalidation at the clock edge.
// The read port is combinational on the registered state, so a lookup
// in the same cycle as a write sees the old contents.
// Assumes: invalidate has priority over an update in the same cycle.
module btb_store #(
    parameter int ADDR_W  = btb_pkg::BTB_ADDR_W,
    parameter int IDX_W   = btb_pkg::BTB_IDX_W,
    parameter int IDX_LSB = btb_pkg::BTB_IDX_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_all,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-IDX_W-IDX_LSB-1:0] rd_tag,
    output logic [ADDR_W-1:0] rd_target
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W - IDX_LSB;

    logic [ENTRIES-1:0] valid_vec;
    logic [TAG_W-1:0]   tag_arr [ENTRIES];
    logic [ADDR_W-1:0]  tgt_arr [ENTRIES];

    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic             do_alloc;
    logic             do_clear;

    // Decode the training request into allocate or tag-guarded clear.
    always_comb begin
        wr_idx   = upd_pc[IDX_LSB +: IDX_W];
        wr_tag   = upd_pc[ADDR_W-1 -: TAG_W];
        do_alloc = upd_valid && upd_taken && !upd_target[0];
        do_clear = upd_valid && !upd_taken && valid_vec[wr_idx]
                   && (tag_arr[wr_idx] == wr_tag);
    end

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
            logic             v_r;
            logic [TAG_W-1:0] tag_r;
            logic [ADDR_W-1:0] tgt_r;
            logic             sel;

            assign sel = (wr_idx == IDX_W'(gi));

            // Valid bit: reset, global clear, allocate, or guarded clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                 v_r <= 1'b0;
                else if (flush_all)         v_r <= 1'b0;
                else if (sel && do_alloc)   v_r <= 1'b1;
                else if (sel && do_clear)   v_r <= 1'b0;
            end

            // Tag and target payload, written only on allocation.
            always_ff @(posedge clk) begin
                if (!flush_all && sel && do_alloc) begin
                    tag_r <= wr_tag;
                    tgt_r <= upd_target;
                end
            end

            assign valid_vec[gi] = v_r;
            assign tag_arr[gi]   = tag_r;
            assign tgt_arr[gi]   = tgt_r;
        end
    endgenerate

    // Combinational read of the entry selected by the fetch address.
    always_comb begin
        rd_valid  = valid_vec[rd_idx];
        rd_tag    = tag_arr[rd_idx];
        rd_target = tgt_arr[rd_idx];
    end

    // R9: global invalidate empties the table by the next cycle.
    a_r9_invalidate_all: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0));

    // R7: an odd-target taken update leaves all valid bits unchanged.
    a_r7_odd_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_target[0] && !flush_all) |=> $stable(valid_vec));

    // R5: an even-target taken update marks its entry valid.
    a_r5_alloc_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && !upd_target[0] && !flush_all)
        |=> valid_vec[$past(upd_pc[IDX_LSB +: IDX_W])]);
endmodule

// File: rtl/btb_lookup.sv
// Module: btb_lookup
// Compares the entry read for the current fetch address against its tag
// and picks the next fetch address: the stored target on a hit, the next
// sequential word otherwise. Assumes a fixed 4-byte fetch increment.
module btb_lookup #(
    parameter int ADDR_W  = btb_pkg::BTB_ADDR_W,
    parameter int IDX_W   = btb_pkg::BTB_IDX_W,
    parameter int IDX_LSB = btb_pkg::BTB_IDX_LSB
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              rd_valid,
    input  logic [ADDR_W-IDX_W-IDX_LSB-1:0] rd_tag,
    input  logic [ADDR_W-1:0] rd_target,
    output logic              hit,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int TAG_W   = ADDR_W - IDX_W - IDX_LSB;
    localparam int FETCH_B = 1 << IDX_LSB;

    // Hit decision and next-address selection.
    always_comb begin
        hit       = enable && rd_valid && (rd_tag == fetch_addr[ADDR_W-1 -: TAG_W]);
        next_addr = hit ? rd_target : (fetch_addr + ADDR_W'(FETCH_B));
    end
endmodule

// File: rtl/btb_fetch_gen.sv
// Module: btb_fetch_gen
// The fetch address register. It loads the reset address under
// synchronous reset and the chosen next address on every other cycle.
// It checks the sequential and redirect behaviour of its own output.
module btb_fetch_gen #(
    parameter int ADDR_W = btb_pkg::BTB_ADDR_W,
    parameter logic [ADDR_W-1:0] RESET_PC = 'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] fetch_addr
);
    // Advance the fetch address once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_addr <= RESET_PC;
        else        fetch_addr <= next_addr;
    end

    // R2: without a hit, the fetch address steps by one word.
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(4)));

    // R3: after a hit, fetch resumes at the stored target.
    a_r3_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (fetch_addr == $past(redirect_addr)));
endmodule

// File: rtl/btb_fetch_top.sv
// Module: btb_fetch_top
// Fetch-stage branch target cache with its fetch address register.
// Each cycle the current fetch address is looked up. A hit raises
// fetch_flush and redirects fetch to the stored target. The execute
// stage trains the table through the update port.
// Assumes the surrounding fetch pipeline acts on fetch_flush in the
// same cycle it is raised.
module btb_fetch_top #(
    parameter int ADDR_W  = btb_pkg::BTB_ADDR_W,
    parameter int IDX_W   = btb_pkg::BTB_IDX_W,
    parameter int IDX_LSB = btb_pkg::BTB_IDX_LSB,
    parameter logic [ADDR_W-1:0] RESET_PC = 'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bp_enable,
    input  logic              flush_all,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_flush
);
    localparam int TAG_W = ADDR_W - IDX_W - IDX_LSB;

    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_target;
    logic [ADDR_W-1:0] next_addr;
    logic              hit;

    btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_all  (flush_all),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_target (upd_target),
        .upd_taken  (upd_taken),
        .rd_idx     (fetch_addr[IDX_LSB +: IDX_W]),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_target  (rd_target)
    );

    btb_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_lookup (
        .enable     (bp_enable),
        .fetch_addr (fetch_addr),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_target  (rd_target),
        .hit        (hit),
        .next_addr  (next_addr)
    );

    btb_fetch_gen #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .redirect      (hit),
        .redirect_addr (rd_target),
        .next_addr     (next_addr),
        .fetch_addr    (fetch_addr)
    );

    assign fetch_flush = hit;

    // R4: with predictions disabled the flush strobe stays low.
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_enable |-> !fetch_flush);

    // R3: a redirect target is always 2-byte aligned.
    a_r3_even_target: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_flush |-> !rd_target[0]);
endmodule

// File: tb/btb_fetch_top_test.sv
// Scoreboard bench: the driver task applies one cycle of stimulus, pushes
// the expected fetch address and flush taken from its own table model,
// and the monitor pops and compares them against the ports.
module btb_fetch_top_test;
    localparam int AW = 32;
    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bp_enable = 1'b1;
    logic flush_all = 1'b0;
    logic upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_target = '0;
    logic upd_taken = 1'b0;
    logic [AW-1:0] fetch_addr;
    logic fetch_flush;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [32:0] exp_q [$];
    string       lbl_q [$];

    bit          mv   [64];
    logic [23:0] mtag [64];
    logic [31:0] mtgt [64];
    logic [31:0] mpc;

    btb_fetch_top #(.RESET_PC(RST_PC)) uut (
        .clk(clk), .rst_n(rst_n), .bp_enable(bp_enable), .flush_all(flush_all),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
        .upd_taken(upd_taken), .fetch_addr(fetch_addr), .fetch_flush(fetch_flush)
    );

    always #4 clk = ~clk;

    // One cycle of stimulus plus the model's prediction for that cycle.
    task automatic step(input string lbl, input bit en, input bit inv, input bit uv,
                        input logic [31:0] upc, input logic [31:0] utg, input bit utk);
        logic [5:0]  ix;
        logic [5:0]  ui;
        bit          h;
        logic [31:0] nx;
        @(negedge clk);
        rst_n = 1'b1;
        bp_enable = en; flush_all = inv; upd_valid = uv;
        upd_pc = upc; upd_target = utg; upd_taken = utk;
        #1;
        ix = mpc[7:2];
        h  = en && mv[ix] && (mtag[ix] == mpc[31:8]);
        exp_q.push_back({h, mpc});
        lbl_q.push_back(lbl);
        nx = h ? mtgt[ix] : mpc + 32'd4;
        if (inv) begin
            for (int i = 0; i < 64; i++) mv[i] = 1'b0;
        end else if (uv) begin
            ui = upc[7:2];
            if (utk && !utg[0]) begin
                mv[ui] = 1'b1; mtag[ui] = upc[31:8]; mtgt[ui] = utg;
            end else if (!utk && mv[ui] && mtag[ui] == upc[31:8]) begin
                mv[ui] = 1'b0;
            end
        end
        mpc = nx;
    endtask

    task automatic idle(input string lbl);
        step(lbl, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    endtask

    task automatic br(input string lbl, input logic [31:0] pc, input logic [31:0] tg, input bit tk);
        step(lbl, 1'b1, 1'b0, 1'b1, pc, tg, tk);
    endtask

    // Monitor: pop one expected item per cycle and compare at the ports.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [32:0] e;
                string l;
                e = exp_q.pop_front();
                l = lbl_q.pop_front();
                n_tests++;
                if (fetch_addr !== e[31:0] || fetch_flush !== e[32]) begin
                    n_fail++;
                    $display("FAIL %s: addr=%h flush=%b expected addr=%h flush=%b",
                             l, fetch_addr, fetch_flush, e[31:0], e[32]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: cycles=20000 expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin mv[i] = 1'b0; mtag[i] = '0; mtgt[i] = '0; end
        mpc = RST_PC;
        repeat (3) @(posedge clk);
        idle("R1 reset state");                               // 1000
        br("R5 allocate", 32'h1010, 32'h2000, 1'b1);          // 1004
        idle("R2 seq");                                       // 1008
        idle("R2 seq");                                       // 100C
        idle("R3 hit redirect");                              // 1010 -> 2000
        idle("R2 seq after redirect");                        // 2000
        br("R8 same-index update sees old", 32'h2004, 32'h3000, 1'b1); // 2004
        br("R7 odd target", 32'h2010, 32'h2101, 1'b1);        // 2008
        idle("R2 seq");                                       // 200C
        idle("R10 alias miss");                               // 2010
        br("R5 allocate loop", 32'h2020, 32'h1008, 1'b1);     // 2014
        idle("R2 seq");                                       // 2018
        idle("R2 seq");                                       // 201C
        idle("R3 hit back");                                  // 2020 -> 1008
        br("R7 odd overwrite", 32'h1010, 32'h1111, 1'b1);     // 1008
        idle("R2 seq");                                       // 100C
        idle("R7 old target kept");                           // 1010 -> 2000
        br("R6 clear tag mismatch", 32'h3010, 32'h0, 1'b0);   // 2000
        idle("R5 R8 later visible");                          // 2004 -> 3000
        br("R6 clear matching", 32'h1010, 32'h0, 1'b0);       // 3000
        br("R5 allocate", 32'h300C, 32'h1010, 1'b1);          // 3004
        idle("R2 seq");                                       // 3008
        idle("R3 hit");                                       // 300C -> 1010
        idle("R6 cleared entry misses");                      // 1010
        br("R5 allocate", 32'h1018, 32'h3010, 1'b1);          // 1014
        step("R4 disabled no hit", 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0); // 1018
        br("R4 re-enable prep", 32'h1020, 32'h1018, 1'b1);    // 101C
        idle("R3 hit");                                       // 1020 -> 1018
        step("R9 invalidate lookup old", 1'b1, 1'b1, 1'b1, 32'h1014, 32'h2000, 1'b1); // 1018 -> 3010
        br("R9 allocate after invalidate", 32'h3018, 32'h1014, 1'b1); // 3010
        idle("R2 seq");                                       // 3014
        idle("R3 new entry hit");                             // 3018 -> 1014
        idle("R9 update lost to invalidate");                 // 1014
        idle("R9 entry cleared");                             // 1018
        idle("R2 seq");                                       // 101C
        idle("R9 entry cleared");                             // 1020
        idle("R2 seq");                                       // 1024
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule